// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive engine of a half-duplex synchronous serial port in master mode. It drives the shift clock on `sck`, whose rate comes from a programmable divisor. On each falling edge of that clock it samples the data line `sdi`. It builds 8-bit or 9-bit words, least-significant bit first, and reports each finished word through a completion flag. An interrupt output can be enabled to follow that flag.

Software sets up the port through a 7-bit configuration register and a divisor register. It then arms either one word (single mode) or a stream of words (continuous mode). When a word is ready, software takes the byte from `rx_data` and the ninth bit from `rx_bit9`, and pulses `rd_stb` to acknowledge it. If a word finishes while the previous word is still unread, the new word is dropped and an overrun is reported. The overrun stays set until a configuration write clears the continuous enable.

Top module: `sync_rx_master`

## Requirements
- R1: The receiver runs only while configuration bits 0 (port on), 1 (synchronous select) and 2 (master clock) are all 1 and at least one of bit 4 (single) or bit 5 (continuous) is 1. Whenever it is not running, `sck` is low.
- R2: Once the receiver starts, `sck` stays low for 2*(D+1) clocks, then toggles every 2*(D+1) clocks. This gives a period of 4*(D+1) clocks, where D is the value last written to the divisor register.
- R3: `sdi` is captured on each falling edge of `sck`. Bits fill the word LSB first, and the low eight bits of a completed word appear on `rx_data`.
- R4: With configuration bit 3 set, a word is nine bits long and its last bit appears on `rx_bit9`. With bit 3 clear, a word is eight bits long and `rx_bit9` reads 0.
- R5: In single mode (bit 4 set, bit 5 clear), exactly one word is received. Bit 4 then clears by itself, and `sck` stays low afterwards.
- R6: With bit 5 set, words are received back to back until bit 5 is written 0. If bits 4 and 5 are both set, continuous operation applies and bit 4 stays set.
- R7: `rx_done` goes high in the clock cycle after the last bit of a word is captured. A pulse on `rd_stb` clears it. `irq` is high exactly when `rx_done` and configuration bit 6 are both 1.
- R8: If a word completes while `rx_done` is still high and `rd_stb` is not asserted in that same cycle, `rx_ovr` sets and `rx_data` and `rx_bit9` keep their old values.
- R9: `rx_ovr` stays set until a configuration write carries bit 5 as 0; that write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 7 | Configuration value (bit 0 on, 1 sync, 2 master, 3 nine-bit, 4 single, 5 continuous, 6 irq enable) |
| div_wr | input | 1 | Write strobe for the divisor register |
| div_wdata | input | DIV_W | Divisor value D |
| rd_stb | input | 1 | Data read acknowledge, clears the completion flag |
| cfg_q | output | 7 | Current configuration register contents |
| rx_data | output | 8 | Low eight bits of the last stored word |
| rx_bit9 | output | 1 | Ninth bit of the last stored word |
| rx_done | output | 1 | Word-complete flag |
| rx_ovr | output | 1 | Overrun flag |
| irq | output | 1 | Receive interrupt |
| sck | output | 1 | Shift clock driven out |
| sdi | input | 1 | Serial data in |

## Verification
The embedded assertions check several rules on every cycle:
- `sck` rises only while the receiver runs and drops low once it stops.
- The completion flag is raised only on a falling clock edge.
- The self-clear of the single enable happens only on such an edge.
- The overrun flag holds until a write clears the continuous bit.
- Stored data stays put while unread.

Other behaviours only the bench scenarios can show. These include the exact clock period for different divisors and the LSB-first bit order against a modelled slave. They also include dropping words on overrun in continuous mode, the precedence when both enables are set, and the ninth-bit path.

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [6:0]       cfg_wdata,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             rd_stb,
  output logic [6:0]       cfg_q,
  output logic [7:0]       rx_data,
  output logic             rx_bit9,
  output logic             rx_done,
  output logic             rx_ovr,
  output logic             irq,
  output logic             sck,
  input  logic             sdi
);
  localparam int PH_W = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [PH_W-1:0]  ph;
  logic [3:0]       bitcnt;
  logic [8:0]       sh, word;
  logic             run, half_end, fall, last, done_evt, pending;

  assign run      = cfg_q[0] & cfg_q[1] & cfg_q[2] & (cfg_q[4] | cfg_q[5]);
  assign half_end = (ph == {div_q, 1'b1});
  assign fall     = run & half_end & sck;
  assign last     = (bitcnt == (cfg_q[3] ? 4'd8 : 4'd7));
  assign done_evt = fall & last;
  assign pending  = rx_done & ~rd_stb;
  assign irq      = rx_done & cfg_q[6];

  always_comb begin
    word = sh;
    word[bitcnt] = sdi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= '0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_wdata;
      else if (done_evt && !cfg_q[5]) cfg_q[4] <= 1'b0;
      if (div_wr) div_q <= div_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0; sck <= 1'b0; bitcnt <= '0; sh <= '0;
    end else if (!run) begin
      ph <= '0; sck <= 1'b0; bitcnt <= '0; sh <= '0;
    end else if (half_end) begin
      ph  <= '0;
      sck <= ~sck;
      if (sck) begin
        sh     <= word;
        bitcnt <= last ? 4'd0 : bitcnt + 4'd1;
      end
    end else begin
      ph <= ph + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_bit9 <= 1'b0; rx_done <= 1'b0; rx_ovr <= 1'b0;
    end else begin
      if (done_evt && !pending) begin
        rx_data <= word[7:0];
        rx_bit9 <= cfg_q[3] & word[8];
        rx_done <= 1'b1;
      end else if (rd_stb) begin
        rx_done <= 1'b0;
      end
      if (done_evt && pending) rx_ovr <= 1'b1;
      else if (cfg_wr && !cfg_wdata[5]) rx_ovr <= 1'b0;
    end
  end

  // R1: clock idles low when stopped, rises only when running
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck);
  a_r1_rise_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $past(run));
  // R7: flag raised only on a falling shift-clock edge
  a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> ($past(sck) && !sck));
  // R5: self-clear of single enable only at a word end
  a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cfg_q[4]) && !$past(cfg_wr)) |-> ($past(sck) && !sck));
  // R9: overrun holds until cleared by a write with continuous bit low
  a_r9_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && !(cfg_wr && !cfg_wdata[5])) |=> rx_ovr);
  // R8: unread data is never overwritten
  a_r8_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rd_stb) |=> ($stable(rx_data) && $stable(rx_bit9)));
endmodule

// File: tb/sync_rx_master_test.sv
module sync_rx_master_test;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, div_wr = 0, rd_stb = 0, sdi = 0;
  logic [6:0] cfg_wdata = 0;
  logic [7:0] div_wdata = 0;
  logic [6:0] cfg_q;
  logic [7:0] rx_data;
  logic rx_bit9, rx_done, rx_ovr, irq, sck;
  int checks = 0, errors = 0;
  logic [8:0] tx_words [0:7];
  int tx_bit = 0, tx_wi = 0, tx_n = 8;

  always #5 clk = ~clk;

  sync_rx_master #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .div_wr(div_wr), .div_wdata(div_wdata), .rd_stb(rd_stb), .cfg_q(cfg_q),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done), .rx_ovr(rx_ovr),
    .irq(irq), .sck(sck), .sdi(sdi));

  always @(posedge sck) begin
    sdi = tx_words[tx_wi][tx_bit];
    tx_bit++;
    if (tx_bit == tx_n) begin tx_bit = 0; tx_wi = (tx_wi + 1) % 8; end
  end

  function automatic logic [8:0] exp_word(logic [8:0] w, logic wide);
    return wide ? w : {1'b0, w[7:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcfg(logic [6:0] v);
    @(negedge clk); cfg_wdata = v; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic wdiv(logic [7:0] v);
    @(negedge clk); div_wdata = v; div_wr = 1;
    @(negedge clk); div_wr = 0;
  endtask

  task automatic rd();
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0;
  endtask

  task automatic arm_slave(logic wide);
    tx_bit = 0; tx_wi = 0; tx_n = wide ? 9 : 8;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!rx_done && n < 20000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic w9;
    int cnt;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset sck", sck, 0);
    chk("R7 reset done", rx_done, 0);
    chk("R8 reset ovr", rx_ovr, 0);
    chk("R7 reset irq", irq, 0);

    // R1: missing master bit keeps clock idle
    wcfg(7'b001_0011);
    cnt = 0;
    repeat (100) begin @(negedge clk); if (sck) cnt++; end
    chk("R1 no master no clock", cnt, 0);
    wcfg(7'b000_0111);
    cnt = 0;
    repeat (100) begin @(negedge clk); if (sck) cnt++; end
    chk("R1 no enable no clock", cnt, 0);

    // R2: period measurement with D=2
    wdiv(8'd2);
    tx_words[0] = 9'h0A5; arm_slave(0);
    wcfg(7'b001_0111);
    cnt = 0;
    while (!sck) begin @(negedge clk); cnt++; end
    chk("R2 first high", cnt, 6);
    cnt = 0;
    while (sck) begin @(negedge clk); cnt++; end
    while (!sck) begin @(negedge clk); cnt++; end
    chk("R2 period", cnt, 12);
    wait_done();
    @(negedge clk);
    chk("R3 lsb first data", rx_data, 8'hA5);
    chk("R5 single cleared", cfg_q[4], 0);
    chk("R4 bit9 zero in 8-bit", rx_bit9, 0);
    chk("R7 irq off", irq, 0);
    cnt = 0;
    repeat (60) begin @(negedge clk); if (sck) cnt++; end
    chk("R5 idle after word", cnt, 0);
    rd();
    chk("R7 read clears", rx_done, 0);

    // R4 nine-bit with irq, D=0
    wdiv(8'd0);
    tx_words[0] = 9'h13C; arm_slave(1);
    wcfg(7'b101_1111);
    wait_done();
    chk("R7 irq on", irq, 1);
    chk("R4 ninth bit", rx_bit9, 1);
    chk("R4 low byte", rx_data, 8'h3C);
    rd();

    // random single words
    for (int i = 0; i < 8; i++) begin
      w9 = 1'($urandom_range(0, 1));
      tx_words[0] = 9'($urandom);
      wdiv(8'($urandom_range(0, 3)));
      arm_slave(w9);
      wcfg({3'b001, w9, 3'b111});
      wait_done();
      @(negedge clk);
      chk("R3 random data", {rx_bit9, rx_data}, exp_word(tx_words[0], w9));
      chk("R5 random single clear", cfg_q[4], 0);
      rd();
    end

    // R6 continuous with single also set
    wdiv(8'd1);
    for (int i = 0; i < 8; i++) tx_words[i] = 9'($urandom);
    arm_slave(0);
    wcfg(7'b011_0111);
    for (int i = 0; i < 3; i++) begin
      wait_done();
      chk("R6 stream word", rx_data, tx_words[i][7:0]);
      rd();
    end
    chk("R6 single stays set", cfg_q[4], 1);
    wcfg(7'b000_0111);
    @(negedge clk);
    cnt = 0;
    repeat (60) begin @(negedge clk); if (sck) cnt++; end
    chk("R6 stops after clear", cnt, 0);

    // R8/R9 overrun
    arm_slave(0);
    wcfg(7'b010_0111);
    wait_done();
    d = rx_data;
    chk("R6 first stream word", d, tx_words[0][7:0]);
    cnt = 0;
    while (!rx_ovr && cnt < 20000) begin @(negedge clk); cnt++; end
    chk("R8 overrun set", rx_ovr, 1);
    chk("R8 data kept", rx_data, d);
    wcfg(7'b010_0111);
    chk("R9 ovr held by write with cont", rx_ovr, 1);
    wcfg(7'b000_0111);
    chk("R9 ovr cleared", rx_ovr, 0);
    chk("R8 old data still", rx_data, d);
    rd();
    chk("R7 done cleared", rx_done, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule